// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Protocol Engine

This block is the bus-facing half of a 256-byte serial nonvolatile memory model. It watches a two-wire bus (serial clock and serial data), cleans both lines, and finds bus start and stop events. After a start it decodes the slave byte. Memory accesses and protect-register accesses take separate paths. The block handles the word-address byte, shifts out read data, and keeps the internal address pointer. It drives only an open-drain pull-down enable for the data line.

The byte array sits outside the block. A combinational read port serves it: the engine presents the pointer and takes back the byte at that address. Each received write byte leaves on a valid/ready stream together with its target address and a flag that marks protect-register traffic, so a page-write stage can collect the bytes and commit them. Back-pressure rule: a byte stays presented, unchanged, until it is accepted. If a further write byte completes on the bus while one is still waiting, that byte is refused with a high acknowledge and discarded. The engine then ignores the bus until the next start.

Top module: `eeprom_slave_engine`

## Requirements
- R1: The block responds to nothing until a start (data falls while clock is high). Any stop (data rises while clock is high) releases the data line and returns the block to idle. After reset the data line is released and no write byte is presented.
- R2: The slave byte is bit 7 first. Bits 7..4 = 1010 select memory and 0110 selects the protect register. Bits 3..1 must equal `strap`. Bit 0 is 1 for read and 0 for write. Any other byte, and a read of the protect register, gets no acknowledge. The block then ignores all further bytes until the next start.
- R3: The block pulls data low for the whole ninth clock after an accepted slave byte and after every accepted word-address or write-data byte.
- R4: Each accepted write-data byte is presented once on the write stream, with its address and with `wr_prot` = 0 for memory.
- R5: The first data byte of a memory write goes to the word address. Each later byte goes to the previous address with its low 4 bits incremented modulo 16, and the upper 4 bits unchanged.
- R6: Read bytes are sent bit 7 first. The data line changes only after a clock falling edge. A low master acknowledge makes the next byte follow. A high one stops the output until a stop. A random read is a memory write carrying only a word address, then a repeated start and a read.
- R7: After a read whose last byte came from address n, a current read starts at n+1. After a memory write, it starts at the address of the last byte written.
- R8: Sequential reads step the pointer through all 256 addresses and wrap from FFh to 00h.
- R9: A start followed directly by a stop, with no clock rise between them, cancels the command. If the cancelled start came during a read command, the pointer becomes invalid. Reads then return FFh until a word-address byte reloads the pointer.
- R10: A presented write byte and its address and flag stay stable until `wr_ready` is seen high. A data byte that completes while a byte is still waiting gets no acknowledge and is dropped.
- R11: Protect-register writes (type 0110) are acknowledged like memory writes. Their data bytes appear on the stream with `wr_prot` = 1, and they leave the pointer unchanged.
- R12: Each bus line passes a two-flop synchronizer and a three-sample majority filter, so a pulse of one system clock has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line (as seen on the wire) |
| strap | input | 3 | Device select pins compared with slave byte bits 3..1 |
| sda_oe | output | 1 | 1 = pull the data line low |
| mem_rd_addr | output | 8 | Read pointer to the byte array |
| mem_rd_data | input | 8 | Byte at `mem_rd_addr` |
| wr_valid | output | 1 | Write byte presented |
| wr_ready | input | 1 | Downstream accepts the presented byte |
| wr_prot | output | 1 | 1 = byte is protect-register traffic |
| wr_addr | output | 8 | Target address of the presented byte |
| wr_data | output | 8 | Presented write byte |

## Verification
The checker asserts, on every cycle, the properties that hold at all times. The data line is only ever pulled low just after a clock low is seen. A stop always releases the line, and an idle engine never drives it. A waiting write byte holds still. Every newly presented write byte comes with a fresh acknowledge. Protect traffic never moves the pointer. Some behaviours depend on a whole sequence of commands, and only the bench scenarios can show them. These are the pointer values after reads, writes, cancels and protect writes, the page wrap of the address, the array wrap, the FFh returned while the pointer is invalid, address mismatch, and glitch immunity.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] MEM_CODE  = 4'b1010;
  localparam logic [3:0] PROT_CODE = 4'b0110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_HOLD
  } eng_state_t;

  typedef enum logic [1:0] {
    K_SLAVE, K_WADDR, K_WDATA
  } byte_kind_t;
endpackage

// File: rtl/eep_line_filter.sv
module eep_line_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [2:0]             hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= 3'b111;
      filt   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      hist_q <= {hist_q[1:0], sync_q[SYNC_STAGES-1]};
      filt   <= (hist_q[0] & hist_q[1]) | (hist_q[1] & hist_q[2]) |
                (hist_q[0] & hist_q[2]);
    end
  end
endmodule

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/eep_proto_fsm.sv
module eep_proto_fsm
  import eep_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DEV_BITS  = 3,
  parameter int PAGE_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_det,
  input  logic                stop_det,
  input  logic                sda_bit,
  input  logic [DEV_BITS-1:0] strap,
  output logic                sda_oe,
  output logic [AW-1:0]       mem_rd_addr,
  input  logic [7:0]          mem_rd_data,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic                wr_prot,
  output logic [AW-1:0]       wr_addr,
  output logic [7:0]          wr_data,
  output logic                idle
);
  localparam int CNT_W = 4;

  eng_state_t  state;
  byte_kind_t  kind;
  logic [CNT_W-1:0] cnt;
  logic [7:0]  rx_sh, tx_sh;
  logic [AW-1:0] ptr;
  logic        ptr_ok, prot, rd_mode, first_data, in_read;
  logic        cancel_armed, cancel_rd, mack;

  logic        is_mem, is_prot, dev_ok, rw, ack_ok, pend_block;
  logic [AW-1:0] page_next;
  logic [7:0]  rd_byte;

  always_comb begin
    is_mem     = rx_sh[7:4] == MEM_CODE;
    is_prot    = rx_sh[7:4] == PROT_CODE;
    dev_ok     = rx_sh[DEV_BITS:1] == strap;
    rw         = rx_sh[0];
    pend_block = wr_valid && !wr_ready;
    unique case (kind)
      K_SLAVE: ack_ok = dev_ok && (is_mem || (is_prot && !rw));
      K_WADDR: ack_ok = 1'b1;
      default: ack_ok = !pend_block;
    endcase
    page_next = first_data ? ptr :
                {ptr[AW-1:PAGE_BITS], ptr[PAGE_BITS-1:0] + 1'b1};
    rd_byte   = ptr_ok ? mem_rd_data : 8'hFF;
  end

  assign mem_rd_addr = ptr;
  assign idle        = state == ST_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      kind         <= K_SLAVE;
      cnt          <= '0;
      rx_sh        <= '0;
      tx_sh        <= '0;
      ptr          <= '0;
      ptr_ok       <= 1'b1;
      prot         <= 1'b0;
      rd_mode      <= 1'b0;
      first_data   <= 1'b0;
      in_read      <= 1'b0;
      cancel_armed <= 1'b0;
      cancel_rd    <= 1'b0;
      mack         <= 1'b0;
      sda_oe       <= 1'b0;
      wr_valid     <= 1'b0;
      wr_prot      <= 1'b0;
      wr_addr      <= '0;
      wr_data      <= '0;
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;

      if (start_det) begin
        state        <= ST_RX;
        kind         <= K_SLAVE;
        cnt          <= '0;
        sda_oe       <= 1'b0;
        rd_mode      <= 1'b0;
        cancel_armed <= 1'b1;
        cancel_rd    <= in_read;
      end else if (stop_det) begin
        state        <= ST_IDLE;
        sda_oe       <= 1'b0;
        in_read      <= 1'b0;
        cancel_armed <= 1'b0;
        if (cancel_armed && cancel_rd) ptr_ok <= 1'b0;
      end else begin
        if (scl_rise) cancel_armed <= 1'b0;
        unique case (state)
          ST_RX: begin
            if (scl_rise && cnt != CNT_W'(8)) begin
              rx_sh <= {rx_sh[6:0], sda_bit};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_W'(8)) begin
              if (!ack_ok) begin
                state <= ST_IDLE;
              end else begin
                state  <= ST_RX_ACK;
                sda_oe <= 1'b1;
                unique case (kind)
                  K_SLAVE: begin
                    prot    <= is_prot;
                    rd_mode <= rw;
                    if (rw) in_read <= 1'b1;
                    kind    <= K_WADDR;
                  end
                  K_WADDR: begin
                    if (!prot) begin
                      ptr    <= rx_sh[AW-1:0];
                      ptr_ok <= 1'b1;
                    end
                    first_data <= 1'b1;
                    kind       <= K_WDATA;
                  end
                  default: begin
                    wr_valid   <= 1'b1;
                    wr_data    <= rx_sh;
                    wr_prot    <= prot;
                    wr_addr    <= prot ? ptr : page_next;
                    if (!prot) ptr <= page_next;
                    first_data <= 1'b0;
                  end
                endcase
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rd_mode) begin
                tx_sh  <= rd_byte;
                sda_oe <= ~rd_byte[7];
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == CNT_W'(7)) begin
                sda_oe <= 1'b0;
                state  <= ST_TX_ACK;
              end else begin
                tx_sh  <= {tx_sh[6:0], 1'b0};
                sda_oe <= ~tx_sh[6];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_bit;
              ptr  <= ptr + 1'b1;
            end else if (scl_fall) begin
              if (mack) begin
                tx_sh  <= rd_byte;
                sda_oe <= ~rd_byte[7];
                cnt    <= '0;
                state  <= ST_TX;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eeprom_slave_engine.sv
module eeprom_slave_engine #(
  parameter int AW          = 8,
  parameter int DEV_BITS    = 3,
  parameter int PAGE_BITS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_in,
  input  logic                sda_in,
  input  logic [DEV_BITS-1:0] strap,
  output logic                sda_oe,
  output logic [AW-1:0]       mem_rd_addr,
  input  logic [7:0]          mem_rd_data,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic                wr_prot,
  output logic [AW-1:0]       wr_addr,
  output logic [7:0]          wr_data
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, filt;
  logic scl_f, sda_f, scl_rise, scl_fall, start_det, stop_det, eng_idle;

  assign raw   = {scl_in, sda_in};
  assign scl_f = filt[1];
  assign sda_f = filt[0];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    eep_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(raw[g]), .filt(filt[g])
    );
  end

  eep_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_proto_fsm #(.AW(AW), .DEV_BITS(DEV_BITS), .PAGE_BITS(PAGE_BITS)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_f),
    .strap(strap), .sda_oe(sda_oe),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_prot(wr_prot),
    .wr_addr(wr_addr), .wr_data(wr_data), .idle(eng_idle)
  );
endmodule

// File: rtl/eep_engine_chk.sv
module eep_engine_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_f,
  input logic          stop_det,
  input logic          eng_idle,
  input logic          sda_oe,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          wr_prot,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic [AW-1:0] mem_rd_addr
);
  // R6: the line is only newly pulled low after the clock was seen low
  p_oe_rise_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_f));

  // R1: a stop always releases the data line
  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R2: an idle (unaddressed) engine never drives
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle |-> !sda_oe);

  // R10: a waiting write byte holds still
  p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) &&
                                 $stable(wr_addr) && $stable(wr_prot)));

  // R3: every newly presented write byte is acknowledged on the bus
  p_accept_acks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $rose(sda_oe));

  // R11: protect traffic leaves the pointer alone
  p_prot_keeps_ptr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wr_valid) && wr_prot) |-> $stable(mem_rd_addr));
endmodule

bind eeprom_slave_engine eep_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .stop_det(stop_det),
  .eng_idle(eng_idle), .sda_oe(sda_oe), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_prot(wr_prot), .wr_addr(wr_addr),
  .wr_data(wr_data), .mem_rd_addr(mem_rd_addr)
);

// File: tb/sim_eeprom_slave_engine.sv
module sim_eeprom_slave_engine;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] SW = 8'hAA, SR = 8'hAB, PW = 8'h6A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_drv = 1'b1, m_sda = 1'b1, wr_ready = 1'b1;
  logic sda_oe, wr_valid, wr_prot, sda_line;
  logic [7:0] mem_rd_addr, mem_rd_data, wr_addr, wr_data;
  logic [7:0] mem [256];
  logic [7:0] log_addr [32], log_data [32];
  logic       log_prot [32];
  int log_n = 0, checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign sda_line    = m_sda & ~sda_oe;
  assign mem_rd_data = mem[mem_rd_addr];

  eeprom_slave_engine u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_line),
    .strap(STRAP), .sda_oe(sda_oe), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_prot(wr_prot), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(posedge clk) begin
    if (wr_valid && wr_ready) begin
      if (!wr_prot) mem[wr_addr] <= wr_data;
      if (log_n < 32) begin
        log_addr[log_n] <= wr_addr;
        log_data[log_n] <= wr_data;
        log_prot[log_n] <= wr_prot;
      end
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); scl_drv = 1'b1; wq(); m_sda = 1'b0; wq();
    scl_drv = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); scl_drv = 1'b1; wq(); m_sda = 1'b1; wq(2 * Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; wq(); scl_drv = 1'b1; wq(); s = sda_line; wq();
    scl_drv = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(!mack, s);
  endtask

  task automatic set_ptr(input logic [7:0] a);
    bit k;
    bus_start(); send_byte(SW, k); send_byte(a, k);
  endtask

  task automatic cur_read1(input string tag, input logic [7:0] exp);
    bit k; logic [7:0] d;
    bus_start(); send_byte(SR, k); recv_byte(1'b0, d); bus_stop();
    chk(k && d == exp, tag, d, exp);
  endtask

  task automatic t_reset();
    chk(!sda_oe, "R1 reset oe", sda_oe, 0);
    chk(!wr_valid, "R1 reset wr_valid", wr_valid, 0);
  endtask

  task automatic t_no_start();
    bit k;
    scl_drv = 1'b0; wq();
    send_byte(SW, k);
    chk(!k, "R1 no ack without start", k, 0);
    bus_stop();
  endtask

  task automatic t_byte_write();
    bit k1, k2, k3; int n0 = log_n;
    bus_start(); send_byte(SW, k1); send_byte(8'h30, k2); send_byte(8'hC3, k3);
    bus_stop();
    chk(k1, "R3 ack slave", k1, 1);
    chk(k2, "R3 ack word addr", k2, 1);
    chk(k3, "R3 ack data", k3, 1);
    chk(log_n == n0 + 1 && log_addr[n0] == 8'h30 && log_data[n0] == 8'hC3 &&
        !log_prot[n0], "R4 write stream", {log_addr[n0], log_data[n0]}, 16'h30C3);
    cur_read1("R7 current read after write", 8'hC3);
  endtask

  task automatic t_page_write();
    bit k; int n0 = log_n;
    bus_start(); send_byte(SW, k); send_byte(8'h4E, k);
    send_byte(8'hA1, k); send_byte(8'hA2, k); send_byte(8'hA3, k); bus_stop();
    chk(log_n == n0 + 3, "R5 byte count", log_n - n0, 3);
    chk(log_addr[n0] == 8'h4E, "R5 first addr", log_addr[n0], 8'h4E);
    chk(log_addr[n0+1] == 8'h4F, "R5 second addr", log_addr[n0+1], 8'h4F);
    chk(log_addr[n0+2] == 8'h40, "R5 page wrap addr", log_addr[n0+2], 8'h40);
    cur_read1("R7 current read after page write", 8'hA3);
  endtask

  task automatic t_random_read();
    bit k; logic [7:0] d0, d1, d2;
    set_ptr(8'h10);
    bus_start(); send_byte(SR, k);
    recv_byte(1'b1, d0); recv_byte(1'b0, d1); recv_byte(1'b0, d2);
    bus_stop();
    chk(d0 == mem[8'h10], "R6 random read byte0", d0, mem[8'h10]);
    chk(d1 == mem[8'h11], "R6 sequential byte1", d1, mem[8'h11]);
    chk(d2 == 8'hFF, "R6 silent after nak", d2, 8'hFF);
    cur_read1("R7 current read after read", mem[8'h12]);
  endtask

  task automatic t_wrap();
    bit k; logic [7:0] d0, d1, d2;
    set_ptr(8'hFE);
    bus_start(); send_byte(SR, k);
    recv_byte(1'b1, d0); recv_byte(1'b1, d1); recv_byte(1'b0, d2); bus_stop();
    chk(d0 == mem[8'hFE] && d1 == mem[8'hFF], "R8 top bytes", {d0, d1},
        {mem[8'hFE], mem[8'hFF]});
    chk(d2 == mem[8'h00], "R8 wrap to 00", d2, mem[8'h00]);
  endtask

  task automatic t_mismatch();
    bit k1, k2, k3, k4, k5;
    bus_start(); send_byte(SW ^ 8'h02, k1); send_byte(8'h30, k2); bus_stop();
    chk(!k1, "R2 strap mismatch", k1, 0);
    chk(!k2, "R2 ignored after mismatch", k2, 0);
    bus_start(); send_byte(8'hBA, k3); bus_stop();
    chk(!k3, "R2 wrong type", k3, 0);
    bus_start(); send_byte(PW | 8'h01, k4); bus_stop();
    chk(!k4, "R2 protect read refused", k4, 0);
    bus_start(); send_byte(SW, k5); bus_stop();
    chk(k5, "R2 matching byte", k5, 1);
  endtask

  task automatic t_protect();
    bit k1, k2, k3; logic [7:0] d; int n0;
    set_ptr(8'h20);
    bus_start(); send_byte(SR, k1); recv_byte(1'b0, d); bus_stop();
    n0 = log_n;
    bus_start(); send_byte(PW, k1); send_byte(8'h00, k2); send_byte(8'h55, k3);
    bus_stop();
    chk(k1 && k2 && k3, "R11 protect acks", {k1, k2, k3}, 3'b111);
    chk(log_n == n0 + 1 && log_prot[n0] && log_data[n0] == 8'h55,
        "R11 protect stream", log_data[n0], 8'h55);
    cur_read1("R11 pointer untouched", mem[8'h21]);
  endtask

  task automatic t_cancel();
    bit k; logic [7:0] d, d1; int n0 = log_n; logic s;
    bus_start(); bus_stop();
    chk(log_n == n0, "R9 cancel writes nothing", log_n - n0, 0);
    cur_read1("R9 pointer kept after write-side cancel", mem[8'h22]);
    bus_start(); send_byte(SR, k);
    for (int i = 0; i < 8; i++) clk_bit(1'b1, s);
    m_sda = 1'b1; wq(); scl_drv = 1'b1; wq(); m_sda = 1'b0; wq();
    m_sda = 1'b1; wq(2 * Q);
    bus_start(); send_byte(SR, k); recv_byte(1'b1, d); recv_byte(1'b0, d1);
    bus_stop();
    chk(d == 8'hFF && d1 == 8'hFF, "R9 invalid pointer reads FF", {d, d1}, 16'hFFFF);
    set_ptr(8'h20);
    bus_start(); send_byte(SR, k); recv_byte(1'b0, d); bus_stop();
    chk(d == mem[8'h20], "R9 reload by word address", d, mem[8'h20]);
  endtask

  task automatic t_backpressure();
    bit k1, k2; int n0 = log_n;
    wr_ready = 1'b0;
    bus_start(); send_byte(SW, k1); send_byte(8'h60, k1);
    send_byte(8'h11, k1); send_byte(8'h22, k2); bus_stop();
    chk(k1 && !k2, "R10 second byte refused", {k1, k2}, 2'b10);
    chk(wr_valid && wr_data == 8'h11 && wr_addr == 8'h60, "R10 byte held",
        wr_data, 8'h11);
    wr_ready = 1'b1; wq(4);
    chk(log_n == n0 + 1 && log_data[n0] == 8'h11, "R10 single delivery",
        log_n - n0, 1);
  endtask

  task automatic t_glitch();
    bit k1, k2, k3; int n0 = log_n;
    bus_start();
    scl_drv = 1'b1; @(negedge clk); scl_drv = 1'b0; wq();
    send_byte(SW, k1);
    m_sda = 1'b0; wq(); m_sda = 1'b1; @(negedge clk); m_sda = 1'b0; wq();
    send_byte(8'h70, k2); send_byte(8'h99, k3); bus_stop();
    chk(k1 && k2 && k3, "R12 glitches ignored", {k1, k2, k3}, 3'b111);
    chk(log_n == n0 + 1 && log_addr[n0] == 8'h70 && log_data[n0] == 8'h99,
        "R12 write intact", log_data[n0], 8'h99);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    wq(5);
    rst_n = 1'b1;
    wq(20);
    t_reset();
    t_no_start();
    t_byte_write();
    t_page_write();
    t_random_read();
    t_wrap();
    t_mismatch();
    t_protect();
    t_cancel();
    t_backpressure();
    t_glitch();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1..R12 run actual=timeout expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule